// File: doc/BRIEF.md
# Indirect Memory Access Window

This block lets a host reach three internal storage spaces through a narrow register port of ten word-wide selects. A plain memory is reached through a pair of address pointers, one for reads and one for writes. Each data access moves the matching pointer on by one dword, so a burst of words streams through a single data select. A bank of peripheral registers is reached through a read and a write address word. Each of these words carries a byte offset and a size field, and a write touches only the low bytes that the size names. A small shared-register space is reached through a control word and a data word. The access starts when the control word is written, and a 2-bit command in that word picks the direction.

Every request on the host port is answered exactly one cycle later. The answer carries read data for reads and zero for writes, so requests may be issued back to back. The three storage spaces are modelled inside the block as arrays. The reset input is asynchronous and active low, and the block releases it internally in step with the clock.

Top module: `idxwin_bridge`

## Requirements
- R1: After reset, both memory pointers, both peripheral address words and the shared control and data words read back as zero.
- R2: A request accepted in cycle N raises rsp_valid in cycle N+1 only. A write answers with rsp_rdata zero. Consecutive requests are each answered in turn.
- R3: Writing select 2 stores the word at memory index wptr[2+:log2(MEM_WORDS)] and then adds 4 to the write pointer (select 1). The pointer reads back through select 1.
- R4: Reading select 3 returns the memory word at the read pointer (select 0) and then adds 4 to that pointer. The pointer reads back through select 0.
- R5: Accesses through select 2 never move the read pointer, and accesses through select 3 never move the write pointer.
- R6: Pointer bits above the memory index and the two low bits are ignored, so address MEM_WORDS*4 reaches the same word as address 0.
- R7: The peripheral write address (select 4) holds a byte offset in bits 15:0 and a size in bits 25:24, where the size is the byte count minus one. Writing select 6 updates only byte lanes 0..size of register offset[2+:log2(PER_REGS)].
- R8: Reading select 7 returns the register named by the peripheral read address (select 5), with the bytes above its size field forced to zero. Peripheral addresses never advance by themselves.
- R9: Writing the shared control word (select 8) with bits 29:28 equal to 3 copies the shared data word (select 9) into shared entry offset[2+:log2(SHR_REGS)], where the offset is taken from bits 15:0.
- R10: Writing the control word with command 2 loads that shared entry into the data word, and the load is visible to a read of select 9 issued next.
- R11: Control writes with command 0 or 1 leave the shared data word and every shared entry unchanged.
- R12: Writes to selects 3 and 7 have no effect. Reads of selects 2 and 6 return zero and move no pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request strobe, one request per cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_sel | input | 4 | Register select 0..9 |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Answer to the request of the previous cycle |
| rsp_rdata | output | 32 | Read data, zero for writes |

## Verification
The hardest situations to reach are the ones where nothing visible is supposed to happen. A shared-register command of 0 or 1 must leave both the data word and the array untouched. The peripheral size field must protect the bytes above it. Neither effect shows on the port when it occurs. The stimulus first fills known values. It then issues the no-op or partial write, and afterwards recovers the guarded state: a command-2 load of the same shared entry, or a full-size peripheral read. Pointer independence is reached by interleaving data reads and writes back to back and then replaying the written region through the read pointer.

// File: rtl/idxwin_pkg.sv
package idxwin_pkg;

  typedef enum logic [3:0] {
    SEL_MEM_RPTR  = 4'd0,
    SEL_MEM_WPTR  = 4'd1,
    SEL_MEM_WDATA = 4'd2,
    SEL_MEM_RDATA = 4'd3,
    SEL_PER_WADDR = 4'd4,
    SEL_PER_RADDR = 4'd5,
    SEL_PER_WDATA = 4'd6,
    SEL_PER_RDATA = 4'd7,
    SEL_SHR_CTRL  = 4'd8,
    SEL_SHR_DATA  = 4'd9
  } sel_e;

  localparam logic [1:0] SHR_CMD_RD = 2'd2;
  localparam logic [1:0] SHR_CMD_WR = 2'd3;

  localparam int OFS_LSB  = 0;
  localparam int SIZE_LSB = 24;
  localparam int CMD_LSB  = 28;

endpackage

// File: rtl/idxwin_mem.sv
module idxwin_mem #(
  parameter int DW    = 32,
  parameter int AW    = 32,
  parameter int WORDS = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_rptr,
  input  logic          ld_wptr,
  input  logic          wr_strobe,
  input  logic          rd_strobe,
  input  logic [DW-1:0] wdata,
  output logic [AW-1:0] rptr,
  output logic [AW-1:0] wptr,
  output logic [DW-1:0] rd_word
);
  localparam int IW = $clog2(WORDS);
  localparam logic [AW-1:0] STEP = AW'(DW / 8);

  logic [DW-1:0] mem_q [WORDS];
  logic [AW-1:0] rptr_q, rptr_d, wptr_q, wptr_d;
  logic          rptr_en, wptr_en;

  always_comb begin
    rptr_en = ld_rptr | rd_strobe;
    wptr_en = ld_wptr | wr_strobe;
    rptr_d  = ld_rptr ? AW'(wdata) : rptr_q + STEP;
    wptr_d  = ld_wptr ? AW'(wdata) : wptr_q + STEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr_q <= '0;
      wptr_q <= '0;
    end else begin
      if (rptr_en) rptr_q <= rptr_d;
      if (wptr_en) wptr_q <= wptr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_strobe) mem_q[wptr_q[2 +: IW]] <= wdata;
  end

  assign rd_word = mem_q[rptr_q[2 +: IW]];
  assign rptr    = rptr_q;
  assign wptr    = wptr_q;

  // R4: a data read advances the read pointer by one dword
  a_r4_rptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !ld_rptr) |=> (rptr_q == $past(rptr_q) + STEP));
  // R5: data reads leave the write pointer alone
  a_r5_wptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !ld_wptr && !wr_strobe) |=> $stable(wptr_q));
  // R5: data writes leave the read pointer alone
  a_r5_rptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_strobe && !ld_rptr && !rd_strobe) |=> $stable(rptr_q));
endmodule

// File: rtl/idxwin_periph.sv
module idxwin_periph #(
  parameter int DW   = 32,
  parameter int REGS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_waddr,
  input  logic          ld_raddr,
  input  logic          wr_strobe,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] waddr,
  output logic [DW-1:0] raddr,
  output logic [DW-1:0] rd_word
);
  import idxwin_pkg::*;
  localparam int IW    = $clog2(REGS);
  localparam int LANES = DW / 8;

  logic [DW-1:0]    regs_q [REGS];
  logic [DW-1:0]    waddr_q, raddr_q;
  logic [IW-1:0]    widx, ridx;
  logic [1:0]       wsize, rsize;
  logic [LANES-1:0] wlane, rlane;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      waddr_q <= '0;
      raddr_q <= '0;
    end else begin
      if (ld_waddr) waddr_q <= wdata;
      if (ld_raddr) raddr_q <= wdata;
    end
  end

  always_comb begin
    widx  = waddr_q[OFS_LSB + 2 +: IW];
    ridx  = raddr_q[OFS_LSB + 2 +: IW];
    wsize = waddr_q[SIZE_LSB +: 2];
    rsize = raddr_q[SIZE_LSB +: 2];
  end

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    assign wlane[b] = (b <= int'(wsize));
    assign rlane[b] = (b <= int'(rsize));
    always_ff @(posedge clk) begin
      if (wr_strobe && wlane[b]) regs_q[widx][8*b +: 8] <= wdata[8*b +: 8];
    end
    assign rd_word[8*b +: 8] = rlane[b] ? regs_q[ridx][8*b +: 8] : 8'h00;
  end

  assign waddr = waddr_q;
  assign raddr = raddr_q;

  // R8: peripheral addresses never advance on their own
  a_r8_raddr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_raddr |=> $stable(raddr_q));
  // R7: the write address holds across data writes
  a_r7_waddr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_strobe && !ld_waddr) |=> $stable(waddr_q));
endmodule

// File: rtl/idxwin_shared.sv
module idxwin_shared #(
  parameter int DW   = 32,
  parameter int REGS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_ctrl,
  input  logic          ld_data,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] ctrl,
  output logic [DW-1:0] data
);
  import idxwin_pkg::*;
  localparam int IW = $clog2(REGS);

  logic [DW-1:0] arr_q [REGS];
  logic [DW-1:0] ctrl_q, data_q, data_d;
  logic [IW-1:0] idx;
  logic [1:0]    cmd;
  logic          do_wr, do_rd, data_en;

  always_comb begin
    idx     = wdata[OFS_LSB + 2 +: IW];
    cmd     = wdata[CMD_LSB +: 2];
    do_wr   = ld_ctrl && (cmd == SHR_CMD_WR);
    do_rd   = ld_ctrl && (cmd == SHR_CMD_RD);
    data_en = ld_data | do_rd;
    data_d  = do_rd ? arr_q[idx] : wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      data_q <= '0;
    end else begin
      if (ld_ctrl) ctrl_q <= wdata;
      if (data_en) data_q <= data_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) arr_q[idx] <= data_q;
  end

  assign ctrl = ctrl_q;
  assign data = data_q;

  // R11: commands 0 and 1 leave the data word untouched
  a_r11_nop_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_ctrl && !wdata[CMD_LSB + 1] && !ld_data) |=> $stable(data_q));
  // R9: a write command does not alter the data word
  a_r9_wr_keeps_data: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_ctrl && (wdata[CMD_LSB +: 2] == 2'd3) && !ld_data) |=> $stable(data_q));
endmodule

// File: rtl/idxwin_bridge.sv
module idxwin_bridge #(
  parameter int DW        = 32,
  parameter int MEM_WORDS = 64,
  parameter int PER_REGS  = 16,
  parameter int SHR_REGS  = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [3:0]    req_sel,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata
);
  import idxwin_pkg::*;

  logic [1:0]    rst_sync_q;
  logic          rst_n_i;
  logic          wr, rd;
  logic [DW-1:0] mem_rptr, mem_wptr, mem_word;
  logic [DW-1:0] per_waddr, per_raddr, per_word;
  logic [DW-1:0] shr_ctrl, shr_data;
  logic [DW-1:0] rdata_d;
  logic          rsp_valid_q;
  logic [DW-1:0] rsp_rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  assign wr = req_valid &  req_write;
  assign rd = req_valid & ~req_write;

  idxwin_mem #(.DW(DW), .AW(DW), .WORDS(MEM_WORDS)) u_mem (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .ld_rptr   (wr && req_sel == SEL_MEM_RPTR),
    .ld_wptr   (wr && req_sel == SEL_MEM_WPTR),
    .wr_strobe (wr && req_sel == SEL_MEM_WDATA),
    .rd_strobe (rd && req_sel == SEL_MEM_RDATA),
    .wdata     (req_wdata),
    .rptr      (mem_rptr),
    .wptr      (mem_wptr),
    .rd_word   (mem_word)
  );

  idxwin_periph #(.DW(DW), .REGS(PER_REGS)) u_per (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .ld_waddr  (wr && req_sel == SEL_PER_WADDR),
    .ld_raddr  (wr && req_sel == SEL_PER_RADDR),
    .wr_strobe (wr && req_sel == SEL_PER_WDATA),
    .wdata     (req_wdata),
    .waddr     (per_waddr),
    .raddr     (per_raddr),
    .rd_word   (per_word)
  );

  idxwin_shared #(.DW(DW), .REGS(SHR_REGS)) u_shr (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .ld_ctrl (wr && req_sel == SEL_SHR_CTRL),
    .ld_data (wr && req_sel == SEL_SHR_DATA),
    .wdata   (req_wdata),
    .ctrl    (shr_ctrl),
    .data    (shr_data)
  );

  always_comb begin
    rdata_d = '0;
    if (rd) begin
      unique case (req_sel)
        SEL_MEM_RPTR:  rdata_d = mem_rptr;
        SEL_MEM_WPTR:  rdata_d = mem_wptr;
        SEL_MEM_RDATA: rdata_d = mem_word;
        SEL_PER_WADDR: rdata_d = per_waddr;
        SEL_PER_RADDR: rdata_d = per_raddr;
        SEL_PER_RDATA: rdata_d = per_word;
        SEL_SHR_CTRL:  rdata_d = shr_ctrl;
        SEL_SHR_DATA:  rdata_d = shr_data;
        default:       rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      rsp_valid_q <= req_valid;
      rsp_rdata_q <= rdata_d;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rsp_rdata_q;

  // R2: every request is answered in the next cycle
  a_r2_answer: assert property (@(posedge clk) disable iff (!rst_n_i)
    req_valid |=> rsp_valid);
  // R2: no answer without a request
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n_i)
    !req_valid |=> !rsp_valid);
  // R2: write answers carry zero
  a_r2_write_zero: assert property (@(posedge clk) disable iff (!rst_n_i)
    (req_valid && req_write) |=> (rsp_rdata == '0));
endmodule

// File: tb/tb_idxwin_bridge.sv
module tb_idxwin_bridge;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [3:0]  req_sel;
  logic [31:0] req_wdata;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;

  int unsigned n_cmp = 0;
  int unsigned n_bad = 0;
  bit          done  = 1'b0;

  logic [31:0] q_exp[$];
  string       q_tag[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  idxwin_bridge dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_sel(req_sel), .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  task automatic issue(input bit w, input logic [3:0] s, input logic [31:0] d,
                       input logic [31:0] exp, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_sel = s; req_wdata = d;
    q_exp.push_back(exp);
    q_tag.push_back(tag);
  endtask

  task automatic wr(input logic [3:0] s, input logic [31:0] d, input string tag);
    issue(1'b1, s, d, 32'h0, tag);
  endtask

  task automatic rd(input logic [3:0] s, input logic [31:0] exp, input string tag);
    issue(1'b0, s, 32'h0, exp, tag);
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; req_sel = 4'd0; req_wdata = '0;
  endtask

  // monitor: pop and compare each answer
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      n_cmp++;
      if (q_exp.size() == 0) begin
        n_bad++;
        $display("FAIL R2 unexpected answer: actual %h expected none", rsp_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        if (rsp_rdata !== e) begin
          n_bad++;
          $display("FAIL %s: actual %h expected %h", t, rsp_rdata, e);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_sel = '0; req_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 reset values
    rd(4'd0, 32'h0, "R1 rptr");
    rd(4'd1, 32'h0, "R1 wptr");
    rd(4'd4, 32'h0, "R1 per waddr");
    rd(4'd5, 32'h0, "R1 per raddr");
    rd(4'd8, 32'h0, "R1 shr ctrl");
    rd(4'd9, 32'h0, "R1 shr data");

    // R3 streamed writes, R2 zero write answers
    wr(4'd1, 32'h10, "R2 wptr load");
    wr(4'd2, 32'hA0A0_0001, "R3 write A");
    wr(4'd2, 32'hB0B0_0002, "R3 write B");
    wr(4'd2, 32'hC0C0_0003, "R3 write C");
    rd(4'd1, 32'h1C, "R3 wptr advanced");

    // R4 streamed reads back to back
    wr(4'd0, 32'h10, "R4 rptr load");
    rd(4'd3, 32'hA0A0_0001, "R4 read A");
    rd(4'd3, 32'hB0B0_0002, "R4 read B");
    rd(4'd3, 32'hC0C0_0003, "R4 read C");
    rd(4'd0, 32'h1C, "R4 rptr advanced");

    // R5 interleaved pointers
    wr(4'd0, 32'h10, "R5 rptr load");
    wr(4'd1, 32'h40, "R5 wptr load");
    rd(4'd3, 32'hA0A0_0001, "R5 read A");
    wr(4'd2, 32'hD0D0_0004, "R5 write D");
    rd(4'd3, 32'hB0B0_0002, "R5 read B");
    wr(4'd2, 32'hE0E0_0005, "R5 write E");
    rd(4'd0, 32'h18, "R5 rptr");
    rd(4'd1, 32'h48, "R5 wptr");
    wr(4'd0, 32'h40, "R5 rptr reload");
    rd(4'd3, 32'hD0D0_0004, "R5 read D");
    rd(4'd3, 32'hE0E0_0005, "R5 read E");

    // R6 aliasing of high pointer bits
    wr(4'd1, 32'h100, "R6 wptr high");
    wr(4'd2, 32'hF0F0_0006, "R6 write F");
    wr(4'd0, 32'h0, "R6 rptr zero");
    rd(4'd3, 32'hF0F0_0006, "R6 alias read");

    // R12 inert selects
    wr(4'd3, 32'hDEAD_BEEF, "R12 write rdata sel");
    rd(4'd2, 32'h0, "R12 read wdata sel");
    rd(4'd6, 32'h0, "R12 read per wdata sel");
    rd(4'd0, 32'h4, "R12 rptr unmoved");
    rd(4'd1, 32'h104, "R12 wptr unmoved");

    // R7 / R8 peripheral byte lanes
    wr(4'd4, 32'h0300_0008, "R7 waddr full");
    wr(4'd6, 32'h1122_3344, "R7 full write");
    wr(4'd5, 32'h0300_0008, "R8 raddr full");
    rd(4'd7, 32'h1122_3344, "R8 full read");
    wr(4'd4, 32'h0000_0008, "R7 waddr size0");
    wr(4'd6, 32'hAABB_CCDD, "R7 byte write");
    rd(4'd7, 32'h1122_33DD, "R7 one lane");
    wr(4'd4, 32'h0100_0008, "R7 waddr size1");
    wr(4'd6, 32'h5566_EEFF, "R7 half write");
    rd(4'd7, 32'h1122_EEFF, "R7 two lanes");
    wr(4'd7, 32'hFFFF_FFFF, "R12 write per rdata");
    rd(4'd7, 32'h1122_EEFF, "R12 per unchanged");
    wr(4'd5, 32'h0000_0008, "R8 raddr size0");
    rd(4'd7, 32'h0000_00FF, "R8 masked read");
    rd(4'd7, 32'h0000_00FF, "R8 no advance");
    rd(4'd5, 32'h0000_0008, "R8 raddr readback");

    // R9 / R10 shared path
    wr(4'd9, 32'hCAFE_F00D, "R9 data");
    wr(4'd8, 32'h3000_000C, "R9 write cmd");
    wr(4'd9, 32'h0, "R10 clear data");
    wr(4'd8, 32'h2000_000C, "R10 read cmd");
    rd(4'd9, 32'hCAFE_F00D, "R10 loaded");
    rd(4'd8, 32'h2000_000C, "R10 ctrl readback");

    // R11 no-op commands
    wr(4'd9, 32'h1234_5678, "R11 data");
    wr(4'd8, 32'h1000_000C, "R11 cmd1");
    rd(4'd9, 32'h1234_5678, "R11 cmd1 data kept");
    wr(4'd8, 32'h0000_000C, "R11 cmd0");
    rd(4'd9, 32'h1234_5678, "R11 cmd0 data kept");
    wr(4'd8, 32'h2000_000C, "R11 reload");
    rd(4'd9, 32'hCAFE_F00D, "R11 entry kept");

    idle();
    repeat (3) @(negedge clk);
    n_cmp++;
    if (q_exp.size() != 0) begin
      n_bad++;
      $display("FAIL R2 answers missing: actual %0d pending expected 0", q_exp.size());
    end
    n_cmp++;
    if (rsp_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL R2 idle: actual %b expected 0", rsp_valid);
    end
    finish_run();
  end
endmodule